// File: doc/BRIEF.md
# MDIO PHY Presence and Link Tracker

This block sits beside the serial engine of an MDIO management controller and keeps two status vectors. Each has one bit per PHY address. The presence vector records whether the most recent management transaction to each address drew an acknowledge from the PHY. The link vector records whether the PHY at each address reported link up the last time its basic status register was read. Transactions started by software and transactions started by automatic polling update both vectors in the same way.

The transaction engine reports each finished transaction with a one-cycle done pulse. The pulse comes with the PHY address, the register address, the direction, the acknowledge sampled during turnaround, and the read data. A small register port lets software read either vector and clear presence bits by writing ones.

Top module: `mdio_phy_status_tracker`

## Requirements
- R1: After reset, both vectors read as all zeros, and `sw_rdata_o` is zero until the first read.
- R2: A done pulse for a read transaction to address n sets presence bit n on the next clock edge when the acknowledge is 1, and clears it when the acknowledge is 0. No other presence bit changes.
- R3: A done pulse for a write transaction (`done_is_read_i` = 0) to address n sets presence bit n, whatever the value of the acknowledge input.
- R4: A software write with `sw_sel_i` = 0 clears every presence bit whose `sw_wdata_i` bit is 1. Presence bits whose `sw_wdata_i` bit is 0 are left unchanged.
- R5: When a software clear and a done pulse target the same presence bit in the same cycle, the bit takes the value from the done pulse.
- R6: A done pulse for an acknowledged read of register address 1 at PHY address n sets link bit n to bit 2 of `done_rdata_i`. The same read without an acknowledge clears link bit n.
- R7: Read transactions to any other register address, and all write transactions, leave the link vector unchanged.
- R8: A software write with `sw_sel_i` = 1 changes neither the link vector nor the presence vector.
- R9: When `sw_rd_i` is 1, `sw_rdata_o` shows the presence vector (`sw_sel_i` = 0) or the link vector (`sw_sel_i` = 1) in the next cycle. The value is the one the vector held before that cycle's updates. When `sw_rd_i` is 0, `sw_rdata_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | 1 | One-cycle pulse for a finished MDIO transaction |
| done_phy_i | input | 5 | PHY address of the finished transaction |
| done_reg_i | input | 5 | Register address of the finished transaction |
| done_is_read_i | input | 1 | 1 = read transaction, 0 = write transaction |
| done_ack_i | input | 1 | Acknowledge sampled during turnaround |
| done_rdata_i | input | 16 | Data returned by a read transaction |
| sw_sel_i | input | 1 | Vector select: 0 = presence, 1 = link |
| sw_rd_i | input | 1 | Software read strobe |
| sw_wr_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 32 | Software write data (ones clear presence bits) |
| sw_rdata_o | output | 32 | Registered read data |

## Verification
A wrong bit in either vector stays hidden until software reads that vector. It then appears on `sw_rdata_o` one cycle after the read strobe, at the bit position of the affected PHY. For that reason the bench reads one of the two vectors in almost every cycle and alternates between them, so a bad update shows within about two cycles. Precedence faults only show when a clear and an update meet on the same bit. A wrong register-address match only shows as a link bit that moves when it should not, or fails to move when it should. The bench therefore drives those collisions and near-miss addresses on purpose.

// File: rtl/mpst_pkg.sv
package mpst_pkg;
    localparam int unsigned MPST_NUM_PHY    = 32;
    localparam int unsigned MPST_REG_W      = 5;
    localparam int unsigned MPST_DATA_W     = 16;
    localparam int unsigned MPST_STATUS_REG = 1;
    localparam int unsigned MPST_LINK_BIT   = 2;

    typedef enum logic {
        SEL_ALIVE = 1'b0,
        SEL_LINK  = 1'b1
    } vec_sel_e;
endpackage

// File: rtl/mpst_alive_vec.sv
module mpst_alive_vec #(
    parameter int unsigned NUM_PHY = 32,
    localparam int unsigned PHY_W  = $clog2(NUM_PHY)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_i,
    input  logic [PHY_W-1:0]   upd_phy_i,
    input  logic               upd_ack_i,
    input  logic               clr_i,
    input  logic [NUM_PHY-1:0] clr_mask_i,
    output logic [NUM_PHY-1:0] alive_o
);
    typedef struct packed {
        logic [NUM_PHY-1:0] alive;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.alive = s_q.alive & ~clr_mask_i;
        end
        // hardware result is applied last so it takes precedence
        if (upd_i) begin
            s_d.alive[upd_phy_i] = upd_ack_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign alive_o = s_q.alive;

    assert_hw_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> alive_o[$past(upd_phy_i)] == $past(upd_ack_i));

    assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> (alive_o & ~$past(alive_o)) == '0);

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !upd_i) |=> (alive_o & $past(clr_mask_i)) == '0);

    assert_hw_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && upd_i && upd_ack_i && clr_mask_i[upd_phy_i]) |=> alive_o[$past(upd_phy_i)]);
endmodule

// File: rtl/mpst_link_vec.sv
module mpst_link_vec #(
    parameter int unsigned NUM_PHY = 32,
    localparam int unsigned PHY_W  = $clog2(NUM_PHY)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_i,
    input  logic [PHY_W-1:0]   upd_phy_i,
    input  logic               upd_ack_i,
    input  logic               upd_link_i,
    output logic [NUM_PHY-1:0] link_o
);
    typedef struct packed {
        logic [NUM_PHY-1:0] link;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (upd_i) begin
            s_d.link[upd_phy_i] = upd_ack_i & upd_link_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign link_o = s_q.link;

    assert_link_needs_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !upd_ack_i) |=> !link_o[$past(upd_phy_i)]);

    assert_link_follows_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && upd_ack_i) |=> link_o[$past(upd_phy_i)] == $past(upd_link_i));

    assert_link_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(link_o));
endmodule

// File: rtl/mpst_read_port.sv
module mpst_read_port
    import mpst_pkg::*;
#(
    parameter int unsigned NUM_PHY = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_i,
    input  logic               sel_i,
    input  logic [NUM_PHY-1:0] alive_i,
    input  logic [NUM_PHY-1:0] link_i,
    output logic [NUM_PHY-1:0] rdata_o
);
    typedef struct packed {
        logic [NUM_PHY-1:0] rdata;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rd_i) begin
            s_d.rdata = (sel_i == SEL_LINK) ? link_i : alive_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o = s_q.rdata;

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

    assert_rdata_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && sel_i) |=> rdata_o == $past(link_i));

    assert_rdata_alive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !sel_i) |=> rdata_o == $past(alive_i));
endmodule

// File: rtl/mdio_phy_status_tracker.sv
module mdio_phy_status_tracker
    import mpst_pkg::*;
#(
    parameter int unsigned NUM_PHY    = MPST_NUM_PHY,
    parameter int unsigned REG_W      = MPST_REG_W,
    parameter int unsigned DATA_W     = MPST_DATA_W,
    parameter int unsigned STATUS_REG = MPST_STATUS_REG,
    parameter int unsigned LINK_BIT   = MPST_LINK_BIT,
    localparam int unsigned PHY_W     = $clog2(NUM_PHY)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done_i,
    input  logic [PHY_W-1:0]   done_phy_i,
    input  logic [REG_W-1:0]   done_reg_i,
    input  logic               done_is_read_i,
    input  logic               done_ack_i,
    input  logic [DATA_W-1:0]  done_rdata_i,
    input  logic               sw_sel_i,
    input  logic               sw_rd_i,
    input  logic               sw_wr_i,
    input  logic [NUM_PHY-1:0] sw_wdata_i,
    output logic [NUM_PHY-1:0] sw_rdata_o
);
    localparam logic [REG_W-1:0] STATUS_ADDR = REG_W'(STATUS_REG);

    logic               ack_eff;
    logic               status_rd;
    logic               alive_clr;
    logic [NUM_PHY-1:0] alive_vec;
    logic [NUM_PHY-1:0] link_vec;
    logic               unused_rdata;

    // write transactions count as acknowledged
    assign ack_eff   = done_is_read_i ? done_ack_i : 1'b1;
    assign status_rd = done_i && done_is_read_i && (done_reg_i == STATUS_ADDR);
    assign alive_clr = sw_wr_i && (sw_sel_i == SEL_ALIVE);
    assign unused_rdata = ^done_rdata_i;

    mpst_alive_vec #(.NUM_PHY(NUM_PHY)) u_alive (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_i      (done_i),
        .upd_phy_i  (done_phy_i),
        .upd_ack_i  (ack_eff),
        .clr_i      (alive_clr),
        .clr_mask_i (sw_wdata_i),
        .alive_o    (alive_vec)
    );

    mpst_link_vec #(.NUM_PHY(NUM_PHY)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_i      (status_rd),
        .upd_phy_i  (done_phy_i),
        .upd_ack_i  (done_ack_i),
        .upd_link_i (done_rdata_i[LINK_BIT]),
        .link_o     (link_vec)
    );

    mpst_read_port #(.NUM_PHY(NUM_PHY)) u_rport (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (sw_rd_i),
        .sel_i   (sw_sel_i),
        .alive_i (alive_vec),
        .link_i  (link_vec),
        .rdata_o (sw_rdata_o)
    );

    assert_write_sets_alive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !done_is_read_i) |=> alive_vec[$past(done_phy_i)]);

    assert_other_reg_no_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && done_reg_i != STATUS_ADDR) |=> $stable(link_vec));

    assert_sw_write_link_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_i && sw_sel_i && !done_i) |=> ($stable(link_vec) && $stable(alive_vec)));

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (alive_vec == '0 && link_vec == '0 && sw_rdata_o == '0));
endmodule

// File: tb/mdio_phy_status_tracker_test.sv
module mdio_phy_status_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done_i = 1'b0;
    logic [4:0]  done_phy_i = '0;
    logic [4:0]  done_reg_i = '0;
    logic        done_is_read_i = 1'b0;
    logic        done_ack_i = 1'b0;
    logic [15:0] done_rdata_i = '0;
    logic        sw_sel_i = 1'b0;
    logic        sw_rd_i = 1'b0;
    logic        sw_wr_i = 1'b0;
    logic [31:0] sw_wdata_i = '0;
    logic [31:0] sw_rdata_o;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_alive = '0;
    logic [31:0] m_link  = '0;
    logic [31:0] m_rdata = '0;

    always #10 clk = ~clk;

    mdio_phy_status_tracker uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .done_i         (done_i),
        .done_phy_i     (done_phy_i),
        .done_reg_i     (done_reg_i),
        .done_is_read_i (done_is_read_i),
        .done_ack_i     (done_ack_i),
        .done_rdata_i   (done_rdata_i),
        .sw_sel_i       (sw_sel_i),
        .sw_rd_i        (sw_rd_i),
        .sw_wr_i        (sw_wr_i),
        .sw_wdata_i     (sw_wdata_i),
        .sw_rdata_o     (sw_rdata_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: sw_rdata_o actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Drive one cycle (called at a negedge), advance the model, compare at next negedge.
    task automatic step(input string tag,
                        input logic dn, input logic [4:0] phy, input logic [4:0] rg,
                        input logic isrd, input logic ack, input logic [15:0] rdat,
                        input logic sel, input logic rd, input logic wr,
                        input logic [31:0] wd);
        done_i = dn; done_phy_i = phy; done_reg_i = rg; done_is_read_i = isrd;
        done_ack_i = ack; done_rdata_i = rdat;
        sw_sel_i = sel; sw_rd_i = rd; sw_wr_i = wr; sw_wdata_i = wd;
        if (rd) m_rdata = sel ? m_link : m_alive;
        if (wr && !sel) m_alive = m_alive & ~wd;
        if (dn) begin
            m_alive[phy] = isrd ? ack : 1'b1;
            if (isrd && rg == 5'd1) m_link[phy] = ack & rdat[2];
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, sw_rdata_o, m_rdata);
    endtask

    task automatic peek(input string tag, input logic sel);
        step(tag, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 16'h0, sel, 1'b1, 1'b0, 32'h0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rdata after reset", sw_rdata_o, 32'h0);
        peek("R1 alive zero", 1'b0);
        peek("R1 link zero", 1'b1);

        // R2: acknowledged and unacknowledged reads
        step("R2 ack read", 1, 5'd3, 5'd0, 1, 1, 16'h0, 0, 1, 0, 0);
        peek("R2 bit3 set", 1'b0);
        step("R2 nack read", 1, 5'd3, 5'd4, 1, 0, 16'h0, 0, 1, 0, 0);
        peek("R2 bit3 cleared", 1'b0);
        step("R2 phy0", 1, 5'd0, 5'd0, 1, 1, 16'h0, 0, 1, 0, 0);
        step("R2 phy31", 1, 5'd31, 5'd0, 1, 1, 16'h0, 0, 1, 0, 0);
        peek("R2 edges set", 1'b0);

        // R3: write transaction sets alive despite ack=0
        step("R3 write txn", 1, 5'd7, 5'd9, 0, 0, 16'h0, 0, 1, 0, 0);
        peek("R3 bit7 set", 1'b0);

        // R4: write-one-to-clear
        step("R4 clear bit0", 0, 5'd0, 5'd0, 0, 0, 16'h0, 0, 1, 1, 32'h0000_0001);
        peek("R4 bit0 cleared", 1'b0);
        step("R4 zero write", 0, 5'd0, 5'd0, 0, 0, 16'h0, 0, 1, 1, 32'h0);
        peek("R4 unchanged", 1'b0);

        // R5: hardware beats software on the same bit
        step("R5 collision", 1, 5'd31, 5'd0, 1, 1, 16'h0, 0, 1, 1, 32'h8000_0080);
        peek("R5 bit31 kept bit7 cleared", 1'b0);

        // R6: link updates on status register reads
        step("R6 link up", 1, 5'd5, 5'd1, 1, 1, 16'h0004, 1, 1, 0, 0);
        peek("R6 link5 set", 1'b1);
        step("R6 link down", 1, 5'd5, 5'd1, 1, 1, 16'hFFFB, 1, 1, 0, 0);
        peek("R6 link5 cleared", 1'b1);
        step("R6 link up again", 1, 5'd5, 5'd1, 1, 1, 16'h0004, 1, 1, 0, 0);
        step("R6 nack status", 1, 5'd5, 5'd1, 1, 0, 16'h0004, 1, 1, 0, 0);
        peek("R6 nack clears link", 1'b1);
        step("R6 phy31 up", 1, 5'd31, 5'd1, 1, 1, 16'h0004, 1, 1, 0, 0);

        // R7: other register reads and write transactions
        step("R7 reg2 read", 1, 5'd9, 5'd2, 1, 1, 16'h0004, 1, 1, 0, 0);
        step("R7 write reg1", 1, 5'd9, 5'd1, 0, 1, 16'h0004, 1, 1, 0, 0);
        step("R7 reg3 read clear attempt", 1, 5'd31, 5'd3, 1, 0, 16'h0, 1, 1, 0, 0);
        peek("R7 link unchanged", 1'b1);

        // R8: software writes to link vector
        step("R8 write link", 0, 5'd0, 5'd0, 0, 0, 16'h0, 1, 1, 1, 32'hFFFF_FFFF);
        peek("R8 link unchanged", 1'b1);
        peek("R8 alive unchanged", 1'b0);

        // R9: hold when not reading
        step("R9 hold", 1, 5'd12, 5'd0, 1, 1, 16'h0, 0, 0, 0, 0);
        step("R9 hold2", 0, 5'd0, 5'd0, 0, 0, 16'h0, 1, 0, 0, 0);
        peek("R9 fresh read", 1'b0);

        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            logic [31:0] w;
            r = $urandom;
            w = $urandom;
            step("R9 mixed traffic", r[0], r[5:1], (r[8] ? 5'd1 : r[13:9]), r[14], r[15],
                 {13'h0, r[16], 2'b0}, r[17], (r[19:18] != 2'b00), (r[22:20] == 3'b000),
                 w & {32{r[23]}} & {32{r[24]}});
        end

        done_i = 1'b0; sw_rd_i = 1'b0; sw_wr_i = 1'b0;
        finish_run();
    end
endmodule